// File: doc/BRIEF.md
# Multi-Bank Scratchpad with Conflict Serialization

The block is an on-chip word memory split into interleaved banks. It is shared by a group of lanes that each present one word request in the same cycle. Each lane's byte address is reduced to a word index. The bank is that word index modulo the bank count, so neighbouring words always sit in neighbouring banks. A request from all lanes is accepted as one unit. The block then executes it as a series of waves, and no wave asks any bank for more than one distinct word.

Lanes that name the same word share one bank access: a read is broadcast to all of them, and this costs nothing extra. Lanes that name different words in the same bank are spread over successive waves. The total cycle count therefore equals the largest number of distinct words requested from any single bank. The block reports that count minus one as the conflict degree. A kernel-level user drives it to measure the cost of an access pattern, or to choose a row stride or layout before committing to it.

Top module: `banked_scratchpad`

## Requirements
- R1: The word index is the byte address shifted right by two; the two low address bits are ignored. The bank is word index mod 32 (BANKS). When every active lane hits a different bank, the request completes in a single wave and the conflict degree is 0.
- R2: Any number of lanes naming the same word are served together in one wave, and this adds nothing to the conflict degree.
- R3: The number of waves equals the maximum, over all banks, of the number of distinct words requested in that bank. `conflict_deg` takes the value waves minus one on the clock edge of the last wave and holds it until the next request finishes.
- R4: For reads at word k·s by lane k across 32 lanes, the conflict degree is as follows. Stride 1 gives 0, stride 2 gives 1, stride 4 gives 3, stride 8 gives 7, stride 16 gives 15 and stride 32 gives 31. Odd strides (3, 5, 33) give 0.
- R5: In each wave, every bank serves the lowest-numbered lane still pending in it, together with all pending lanes naming the same word. Within a bank, words are therefore taken in the order of their lowest requesting lane.
- R6: A request is taken when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` then stays low until the last wave completes. Each wave occupies one cycle, starting on the edge after acceptance. For a lane served in a wave, `lane_done` is high for that one cycle, and the lane's `lane_rdata` is valid during that cycle.
- R7: Every served lane, including a writing lane, returns the word's value from before the request. Writes become visible to later requests.
- R8: When several lanes of one request write the same word, the data of the highest-numbered writing lane is stored.
- R9: Inactive lanes (`lane_act` low) never assert `lane_done`, never write, and never count toward the conflict degree. A request with no active lane leaves `req_ready` high and sets the conflict degree to 0.
- R10: After reset, `req_ready` is 1, `lane_done` is all zero and `conflict_deg` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered this cycle |
| req_ready | output | 1 | Block is idle and can take a request |
| lane_act | input | LANES | Per-lane active flag |
| lane_addr | input | LANES*AW | Per-lane byte address, lane i at bits [i*AW +: AW] |
| lane_wr | input | LANES | Per-lane write flag |
| lane_wdata | input | LANES*DW | Per-lane write data |
| lane_done | output | LANES | Per-lane one-cycle pulse in the lane's wave |
| lane_rdata | output | LANES*DW | Per-lane read data, valid with `lane_done` |
| conflict_deg | output | CW | Waves of the last finished request minus one |

## Verification
The bench applies stride patterns whose degrees are known in closed form. A bank index taken from the wrong address bits would give a degree of 0 for stride 32 instead of 31, and counting lanes rather than distinct words would report broadcasts as 31-way conflicts. Every lane's wave number is compared with the first-appearance order of its word within its bank; a wrong leader choice moves lanes into other waves. The bench also mixes reads and writes to one word, and sends colliding writes, to expose read-after-write leakage and wrong write priority. Inactive lanes are loaded with conflicting write addresses to show that they neither write nor inflate the degree.

// File: rtl/banked_scratchpad.sv
module banked_scratchpad #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int BB    = $clog2(BANKS),
  localparam int WORDS = BANKS * DEPTH,
  localparam int WB    = $clog2(WORDS),
  localparam int AW    = WB + 2,
  localparam int CW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LANES-1:0]    lane_act,
  input  logic [LANES*AW-1:0] lane_addr,
  input  logic [LANES-1:0]    lane_wr,
  input  logic [LANES*DW-1:0] lane_wdata,
  output logic [LANES-1:0]    lane_done,
  output logic [LANES*DW-1:0] lane_rdata,
  output logic [CW-1:0]       conflict_deg
);

  logic             busy;
  logic [LANES-1:0] pend, act_q, wr_q, serve, remaining;
  logic [WB-1:0]    word_q  [LANES];
  logic [DW-1:0]    wdata_q [LANES];
  logic [DW-1:0]    rdata_q [LANES];
  logic [DW-1:0]    mem     [WORDS];
  logic [CW-1:0]    wcnt;

  wire accept = req_valid && !busy;
  assign req_ready = !busy;

  // per-bank leader: lowest pending lane in the same bank; its word is served
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic          found;
      logic [WB-1:0] lw;
      found = 1'b0;
      lw    = '0;
      for (int j = 0; j < LANES; j++) begin
        if (!found && pend[j] && (word_q[j][BB-1:0] == word_q[i][BB-1:0])) begin
          found = 1'b1;
          lw    = word_q[j];
        end
      end
      serve[i] = pend[i] && (lw == word_q[i]);
    end
  end

  assign remaining = pend & ~serve;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      pend         <= '0;
      act_q        <= '0;
      lane_done    <= '0;
      wcnt         <= '0;
      conflict_deg <= '0;
    end else if (accept) begin
      act_q     <= lane_act;
      pend      <= lane_act;
      busy      <= |lane_act;
      wcnt      <= '0;
      lane_done <= '0;
      if (!(|lane_act)) conflict_deg <= '0;
    end else if (busy) begin
      lane_done <= serve;
      pend      <= remaining;
      wcnt      <= wcnt + 1'b1;
      if (remaining == '0) begin
        busy         <= 1'b0;
        conflict_deg <= wcnt;
      end
    end else begin
      lane_done <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      wr_q <= lane_wr;
      for (int i = 0; i < LANES; i++) begin
        word_q[i]  <= lane_addr[i*AW+2 +: WB];
        wdata_q[i] <= lane_wdata[i*DW +: DW];
      end
    end
    if (busy) begin
      for (int i = 0; i < LANES; i++)
        if (serve[i]) rdata_q[i] <= mem[word_q[i]];
      for (int i = 0; i < LANES; i++)
        if (serve[i] && wr_q[i]) mem[word_q[i]] <= wdata_q[i];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign lane_rdata[g*DW +: DW] = rdata_q[g];
  end

  p_accept_drops_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && |lane_act) |=> !req_ready);

  p_empty_stays_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(|lane_act)) |=> (req_ready && lane_done == '0));

  p_wave_progress_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (lane_done != '0));

  p_done_only_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_done & ~act_q) == '0);

  p_deg_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_ready) && req_ready && !$past(req_valid)) |-> $stable(conflict_deg));

endmodule

// File: tb/banked_scratchpad_tb.sv
module banked_scratchpad_tb_top;
  localparam int L   = 32;
  localparam int AW  = 12;
  localparam int DW  = 32;
  localparam int NW  = 1024;
  localparam int CW  = 5;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic req_ready;
  logic [L-1:0] lane_act = '0, lane_wr = '0, lane_done;
  logic [L*AW-1:0] lane_addr = '0;
  logic [L*DW-1:0] lane_wdata = '0, lane_rdata;
  logic [CW-1:0] conflict_deg;

  always #2 clk = ~clk;

  banked_scratchpad dut_i (.clk, .rst_n, .req_valid, .req_ready, .lane_act, .lane_addr,
    .lane_wr, .lane_wdata, .lane_done, .lane_rdata, .conflict_deg);

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] shadow [NW];
  logic [9:0]    t_word [L];
  logic [DW-1:0] t_data [L];
  logic [L-1:0]  t_act, t_wr;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_req();
    t_act = '0; t_wr = '0;
    for (int i = 0; i < L; i++) begin t_word[i] = '0; t_data[i] = '0; end
  endtask

  // generic request: checks waves, degree, per-lane wave order, read data, inactive lanes
  task automatic run_req(input string name, output int deg_seen);
    int exp_rank [L];
    int got_wave [L];
    logic [DW-1:0] got_data [L];
    logic [DW-1:0] old_data [L];
    int cnt [L];
    int exp_waves, waves, bad_rank, bad_data, bad_inact, bad_twice;
    exp_waves = 0;
    for (int b = 0; b < L; b++) cnt[b] = 0;
    for (int i = 0; i < L; i++) begin
      int first_i;
      exp_rank[i] = -1; got_wave[i] = -1; got_data[i] = '0;
      old_data[i] = shadow[t_word[i]];
      if (t_act[i]) begin
        first_i = i;
        for (int j = L-1; j >= 0; j--) if (t_act[j] && t_word[j] == t_word[i]) first_i = j;
        exp_rank[i] = 0;
        for (int j = 0; j < first_i; j++) begin
          bit is_first;
          is_first = t_act[j];
          for (int k = 0; k < j; k++) if (t_act[k] && t_word[k] == t_word[j]) is_first = 0;
          if (is_first && t_word[j][4:0] == t_word[i][4:0] && t_word[j] != t_word[i])
            exp_rank[i]++;
        end
        if (first_i == i) cnt[t_word[i][4:0]]++;
      end
    end
    for (int b = 0; b < L; b++) if (cnt[b] > exp_waves) exp_waves = cnt[b];

    @(negedge clk);
    chk(req_ready == 1'b1, "R6", {name, " ready before request"}, req_ready, 1);
    req_valid = 1;
    lane_act = t_act; lane_wr = t_wr;
    for (int i = 0; i < L; i++) begin
      lane_addr[i*AW +: AW]  = {t_word[i], 2'(i % 4)};  // low bits must be ignored (R1)
      lane_wdata[i*DW +: DW] = t_data[i];
    end
    @(negedge clk);
    req_valid = 0;
    waves = 0; bad_twice = 0;
    if (exp_waves > 0)
      chk(req_ready == 1'b0, "R6", {name, " ready low after accept"}, req_ready, 0);
    else
      chk(req_ready == 1'b1 && lane_done == '0, "R9", {name, " empty request stays ready"}, req_ready, 1);
    while (!req_ready && waves < 64) begin
      @(negedge clk);
      for (int i = 0; i < L; i++)
        if (lane_done[i]) begin
          if (got_wave[i] != -1) bad_twice++;
          got_wave[i] = waves;
          got_data[i] = lane_rdata[i*DW +: DW];
        end
      waves++;
    end
    bad_rank = 0; bad_data = 0; bad_inact = 0;
    for (int i = 0; i < L; i++) begin
      if (t_act[i]) begin
        if (got_wave[i] != exp_rank[i]) bad_rank++;
        if (got_data[i] !== old_data[i]) bad_data++;
      end else if (got_wave[i] != -1) bad_inact++;
    end
    chk(waves == exp_waves, "R3", {name, " wave count"}, waves, exp_waves);
    chk(conflict_deg == CW'(exp_waves > 0 ? exp_waves - 1 : 0), "R3", {name, " conflict degree"},
        conflict_deg, exp_waves > 0 ? exp_waves - 1 : 0);
    chk(bad_rank == 0 && bad_twice == 0, "R5", {name, " lanes in wrong wave"}, bad_rank + bad_twice, 0);
    chk(bad_data == 0, "R7", {name, " read data lanes wrong"}, bad_data, 0);
    chk(bad_inact == 0, "R9", {name, " inactive lanes done"}, bad_inact, 0);
    deg_seen = conflict_deg;
    for (int i = 0; i < L; i++) if (t_act[i] && t_wr[i]) shadow[t_word[i]] = t_data[i];
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && lane_done == '0 && conflict_deg == '0, "R10", "reset state",
        {req_ready, lane_done}, {1'b1, 32'h0});
    rst_n = 1;
  endtask

  task automatic t_fill();
    int d;
    for (int r = 0; r < NW / L; r++) begin
      clear_req();
      t_act = '1; t_wr = '1;
      for (int k = 0; k < L; k++) begin
        t_word[k] = 10'(r * L + k);
        t_data[k] = 32'hA500_0000 ^ ((r * L + k) * 32'h9E37_79B1);
      end
      run_req("R1 fill stride-1", d);
    end
    chk(d == 0, "R1", "distinct banks give degree 0", d, 0);
  endtask

  task automatic t_stride(input int s, input int exp_deg);
    int d;
    clear_req();
    t_act = '1;
    for (int k = 0; k < L; k++) t_word[k] = 10'((k * s) % NW);
    run_req($sformatf("R4 stride %0d", s), d);
    chk(d == exp_deg, "R4", $sformatf("stride %0d degree", s), d, exp_deg);
  endtask

  task automatic t_broadcast();
    int d;
    clear_req(); t_act = '1;
    for (int k = 0; k < L; k++) t_word[k] = 10'd7;
    run_req("R2 full broadcast", d);
    chk(d == 0, "R2", "broadcast degree", d, 0);
    clear_req(); t_act = '1;
    for (int k = 0; k < L; k++) t_word[k] = (k % 2) ? 10'd37 : 10'd5;
    run_req("R2 two words one bank", d);
    chk(d == 1, "R2", "two-word broadcast degree", d, 1);
  endtask

  task automatic t_order();
    int d;
    clear_req();
    t_act = 32'h0000_00FF;
    t_word[0] = 10'd64; t_word[1] = 10'd0;  t_word[2] = 10'd64; t_word[3] = 10'd32;
    t_word[4] = 10'd1;  t_word[5] = 10'd0;  t_word[6] = 10'd33; t_word[7] = 10'd96;
    run_req("R5 leader order", d);
    chk(d == 3, "R5", "mixed order degree", d, 3);
  endtask

  task automatic t_rw_same();
    int d;
    clear_req();
    t_act = 32'h0000_002E;
    t_word[1] = 10'd100; t_word[3] = 10'd100; t_word[5] = 10'd100;
    t_wr[3] = 1; t_data[3] = 32'hDEAD_BEEF;
    run_req("R7 read with write same word", d);
    clear_req(); t_act = 32'h1; t_word[0] = 10'd100;
    run_req("R7 later read sees write", d);
  endtask

  task automatic t_dup_write();
    int d;
    clear_req();
    t_act = 32'h0010_0204;
    t_word[2] = 10'd200; t_word[9] = 10'd200; t_word[20] = 10'd200;
    t_wr = t_act;
    t_data[2] = 32'h1111_1111; t_data[9] = 32'h2222_2222; t_data[20] = 32'h3333_3333;
    run_req("R8 colliding writes", d);
    clear_req(); t_act = 32'h2; t_word[1] = 10'd200;
    run_req("R8 readback", d);
    chk(shadow[200] == 32'h3333_3333, "R8", "bench model highest lane", shadow[200], 32'h3333_3333);
  endtask

  task automatic t_inactive();
    int d;
    clear_req();
    t_act = 32'h0000_00FF;
    for (int k = 0; k < L; k++) begin
      t_word[k] = (k < 8) ? 10'(k) : 10'(k * 32 % NW);
      t_data[k] = 32'hBAD0_0000 + k;
    end
    t_wr = 32'hFFFF_FF00;
    run_req("R9 inactive lanes conflict", d);
    chk(d == 0, "R9", "inactive not counted", d, 0);
    clear_req(); t_act = 32'hFFFF_FF00;
    for (int k = 8; k < L; k++) t_word[k] = 10'(k * 32 % NW);
    run_req("R9 inactive writes absent", d);
    clear_req();
    run_req("R9 all lanes inactive", d);
    chk(d == 0, "R9", "empty degree", d, 0);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) shadow[i] = '0;
    t_reset();
    t_fill();
    t_stride(1, 0);  t_stride(2, 1);  t_stride(3, 0);  t_stride(4, 3);
    t_stride(5, 0);  t_stride(8, 7);  t_stride(16, 15); t_stride(32, 31);
    t_stride(33, 0);
    t_broadcast();
    t_order();
    t_rw_same();
    t_dup_write();
    t_inactive();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule